// File: doc/BRIEF.md
# Priority Region Protection Checker

This block decides, for each memory access, whether it may proceed. Software describes up to a parameterised number of address windows (sixteen by default). Each window has a base word and a permission word. A window covers a power-of-two number of bytes and is aligned to its own size. Windows may overlap, and when they do, the window with the smallest index decides. An access that falls in no valid window is judged by a background permission set held in a global control word. A single bit in that word switches protection on or off.

Each check presents an address, a privilege level and an access kind. One clock later the block returns exactly one verdict, grant or deny. Alongside the verdict it reports which window decided, or flags that the background set was used. Configuration goes through a plain address, data and write-enable port, and stored words can be read back on the same address.

Top module: `mpu_guard`

## Requirements
- R1: While `rstN` is low, and after it is released, every stored word reads back as zero and `resValid` is low.
- R2: Window i keeps its permission word at register address 2*i and its base word at 2*i+1. The global control word is at address 2*NUM_REGIONS. A read returns the last word written to that address. Writes to any other address are ignored, and reads of any other address return zero.
- R3: While bit 30 of the control word is clear, every check is granted, with `resRegion` = 0 and `resDefault` = 0.
- R4: Window i matches an address when three conditions hold: bit 0 of its base word (valid) is set; and with size code n = {perm[11:9], perm[1:0]}, the window spans 2^(n+1) bytes; and the address equals the base word in every bit above bit n.
- R5: A window whose size code is below 10 (smaller than 2 KB) never matches.
- R6: When several windows match, the one with the lowest index supplies the permissions.
- R7: Permission bits are: 3 user execute, 4 user write, 5 user read, 6 kernel execute, 7 kernel write, 8 kernel read. `chkKind` 0 is execute, 1 is write and 2 is read. `chkUser`=1 selects the user bits and 0 selects the kernel bits. Grant requires the selected bit to be set.
- R8: When no window matches and protection is on, the control word bits [8:2] are used with the R7 layout.
- R9: `resValid` follows `chkValid` by one clock. While valid, exactly one of `resGrant` and `resDeny` is high. Otherwise both are low.
- R10: With protection on, `resRegion` gives the deciding window, or `resDefault`=1 and `resRegion`=0 when the background set decided.
- R11: With protection on, `chkKind` 3 is always denied, and the deciding window is still reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | REG_AW | Register address for reads and writes |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | DATA_W | Write data |
| regRdData | output | DATA_W | Word stored at `regAddr` (combinational) |
| chkValid | input | 1 | A check is presented this cycle |
| chkAddr | input | DATA_W | Access address |
| chkUser | input | 1 | 1 = user level, 0 = kernel level |
| chkKind | input | 2 | 0 execute, 1 write, 2 read, 3 reserved |
| resValid | output | 1 | Verdict valid, one cycle after `chkValid` |
| resGrant | output | 1 | Access allowed |
| resDeny | output | 1 | Access refused |
| resRegion | output | IDX_W | Index of deciding window |
| resDefault | output | 1 | Background set decided |

## Verification
A stored word that is corrupted, or a size code split the wrong way, changes which window claims an address. That shows up one clock after the check as a wrong `resRegion` or a wrong verdict. The stimulus sits on window edges, on overlaps between windows, and on windows that are invalid or too small, so a one-bit mask error moves the result. A broken priority chain or a mis-decoded write address shows on the very next verdict or readback.

// File: rtl/mpu_guard_pkg.sv
package mpu_guard_pkg;
  // strobes from the register decode to the storage/match datapath
  typedef struct packed {
    logic       permWr;
    logic       baseWr;
    logic       enWr;
    logic       selPerm;
    logic       selBase;
    logic       selEn;
    logic [7:0] idx;
  } regStrobe_t;

  localparam int ON_BIT      = 30;
  localparam int ATTR_BASE   = 3;   // user execute bit; kind adds 0..2
  localparam int KERNEL_OFS  = 3;
  localparam int MIN_CODE    = 10;
endpackage

// File: rtl/mpu_guard_ctrl.sv
module mpu_guard_ctrl
  import mpu_guard_pkg::*;
#(
  parameter int NUM_REGIONS = 16,
  parameter int REG_AW      = 6
) (
  input  logic [REG_AW-1:0] regAddr,
  input  logic              regWrEn,
  output regStrobe_t        strb
);
  localparam int EN_ADDR = 2 * NUM_REGIONS;

  logic inRegionSpace;
  logic isEnAddr;

  always_comb begin
    inRegionSpace = (int'(regAddr) < EN_ADDR);
    isEnAddr      = (int'(regAddr) == EN_ADDR);
    strb.idx      = 8'(regAddr >> 1);
    strb.selPerm  = inRegionSpace && !regAddr[0];
    strb.selBase  = inRegionSpace &&  regAddr[0];
    strb.selEn    = isEnAddr;
    strb.permWr   = regWrEn && strb.selPerm;
    strb.baseWr   = regWrEn && strb.selBase;
    strb.enWr     = regWrEn && strb.selEn;
  end
endmodule

// File: rtl/mpu_guard_dp.sv
module mpu_guard_dp
  import mpu_guard_pkg::*;
#(
  parameter int NUM_REGIONS = 16,
  parameter int DATA_W      = 32,
  parameter int IDX_W       = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strb,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              chkValid,
  input  logic [DATA_W-1:0] chkAddr,
  input  logic              chkUser,
  input  logic [1:0]        chkKind,
  output logic              resValid,
  output logic              resGrant,
  output logic              resDeny,
  output logic [IDX_W-1:0]  resRegion,
  output logic              resDefault
);
  logic [DATA_W-1:0] permQ [NUM_REGIONS];
  logic [DATA_W-1:0] baseQ [NUM_REGIONS];
  logic [DATA_W-1:0] enQ;
  logic [NUM_REGIONS-1:0] hit;

  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_region
    logic [4:0]        code;
    logic [DATA_W-1:0] keep;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        permQ[i] <= '0;
        baseQ[i] <= '0;
      end else begin
        if (strb.permWr && strb.idx == 8'(i)) permQ[i] <= regWrData;
        if (strb.baseWr && strb.idx == 8'(i)) baseQ[i] <= regWrData;
      end
    end

    always_comb begin
      code = {permQ[i][11:9], permQ[i][1:0]};
      for (int b = 0; b < DATA_W; b++) keep[b] = (b > int'(code));
    end

    assign hit[i] = baseQ[i][0] && (int'(code) >= MIN_CODE) &&
                    (((chkAddr ^ baseQ[i]) & keep) == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          enQ <= '0;
    else if (strb.enWr) enQ <= regWrData;
  end

  always_comb begin
    regRdData = '0;
    if (strb.selPerm)      regRdData = permQ[strb.idx[IDX_W-1:0]];
    else if (strb.selBase) regRdData = baseQ[strb.idx[IDX_W-1:0]];
    else if (strb.selEn)   regRdData = enQ;
  end

  // fixed priority: lowest index overrides
  logic [IDX_W-1:0]  winIdx;
  logic              anyHit;
  logic [DATA_W-1:0] attrWord;
  logic              allow;
  int                bitPos;

  always_comb begin
    winIdx = '0;
    anyHit = 1'b0;
    for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
      if (hit[i]) begin
        anyHit = 1'b1;
        winIdx = IDX_W'(i);
      end
    end
    attrWord = anyHit ? permQ[winIdx] : enQ;
    bitPos   = ATTR_BASE + int'(chkKind) + (chkUser ? 0 : KERNEL_OFS);
    allow    = (chkKind != 2'b11) && attrWord[bitPos];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resValid   <= 1'b0;
      resGrant   <= 1'b0;
      resDeny    <= 1'b0;
      resRegion  <= '0;
      resDefault <= 1'b0;
    end else begin
      resValid <= chkValid;
      if (!chkValid) begin
        resGrant   <= 1'b0;
        resDeny    <= 1'b0;
        resRegion  <= '0;
        resDefault <= 1'b0;
      end else if (!enQ[ON_BIT]) begin
        resGrant   <= 1'b1;
        resDeny    <= 1'b0;
        resRegion  <= '0;
        resDefault <= 1'b0;
      end else begin
        resGrant   <= allow;
        resDeny    <= !allow;
        resRegion  <= winIdx;
        resDefault <= !anyHit;
      end
    end
  end
endmodule

// File: rtl/mpu_guard.sv
module mpu_guard
  import mpu_guard_pkg::*;
#(
  parameter  int NUM_REGIONS = 16,
  parameter  int DATA_W      = 32,
  localparam int IDX_W       = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1,
  localparam int REG_AW      = $clog2(2 * NUM_REGIONS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              chkValid,
  input  logic [DATA_W-1:0] chkAddr,
  input  logic              chkUser,
  input  logic [1:0]        chkKind,
  output logic              resValid,
  output logic              resGrant,
  output logic              resDeny,
  output logic [IDX_W-1:0]  resRegion,
  output logic              resDefault
);
  regStrobe_t strb;

  mpu_guard_ctrl #(.NUM_REGIONS(NUM_REGIONS), .REG_AW(REG_AW)) u_ctrl (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .strb    (strb)
  );

  mpu_guard_dp #(.NUM_REGIONS(NUM_REGIONS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .chkValid   (chkValid),
    .chkAddr    (chkAddr),
    .chkUser    (chkUser),
    .chkKind    (chkKind),
    .resValid   (resValid),
    .resGrant   (resGrant),
    .resDeny    (resDeny),
    .resRegion  (resRegion),
    .resDefault (resDefault)
  );
endmodule

// File: rtl/mpu_guard_chk.sv
module mpu_guard_chk #(
  parameter int NUM_REGIONS = 16,
  parameter int DATA_W      = 32,
  parameter int IDX_W       = 4,
  parameter int REG_AW      = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic [REG_AW-1:0] regAddr,
  input logic              regWrEn,
  input logic [DATA_W-1:0] regWrData,
  input logic [DATA_W-1:0] regRdData,
  input logic              chkValid,
  input logic [1:0]        chkKind,
  input logic              resValid,
  input logic              resGrant,
  input logic              resDeny,
  input logic [IDX_W-1:0]  resRegion,
  input logic              resDefault
);
  localparam int EN_ADDR = 2 * NUM_REGIONS;

  logic shadowOn;
  logic mapped;
  assign mapped = (int'(regAddr) <= EN_ADDR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shadowOn <= 1'b0;
    else if (regWrEn && int'(regAddr) == EN_ADDR) shadowOn <= regWrData[30];
  end

  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    chkValid |=> resValid);
  a_r9_idle_follows: assert property (@(posedge clk) disable iff (!rstN)
    !chkValid |=> !resValid);
  a_r9_one_verdict: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> $countones({resGrant, resDeny}) == 1);
  a_r9_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !resValid |-> !resGrant && !resDeny);
  a_r3_off_grants: assert property (@(posedge clk) disable iff (!rstN)
    chkValid && !shadowOn |=> resGrant && !resDefault);
  a_r11_reserved_denied: assert property (@(posedge clk) disable iff (!rstN)
    chkValid && shadowOn && chkKind == 2'b11 |=> resDeny);
  a_r10_default_index: assert property (@(posedge clk) disable iff (!rstN)
    resDefault |-> resRegion == '0 && resValid);
  a_r2_readback: assert property (@(posedge clk) disable iff (!rstN)
    $past(regWrEn) && $past(mapped) && regAddr == $past(regAddr) && !regWrEn
      |-> regRdData == $past(regWrData));
endmodule

bind mpu_guard mpu_guard_chk #(
  .NUM_REGIONS(NUM_REGIONS), .DATA_W(DATA_W), .IDX_W(IDX_W), .REG_AW(REG_AW)
) u_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
  .regWrData(regWrData), .regRdData(regRdData), .chkValid(chkValid),
  .chkKind(chkKind), .resValid(resValid), .resGrant(resGrant),
  .resDeny(resDeny), .resRegion(resRegion), .resDefault(resDefault)
);

// File: tb/mpu_guard_bench.sv
module mpu_guard_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        chkValid = 1'b0;
  logic [31:0] chkAddr = '0;
  logic        chkUser = 1'b0;
  logic [1:0]  chkKind = '0;
  logic        resValid, resGrant, resDeny, resDefault;
  logic [3:0]  resRegion;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;

  mpu_guard u_mpu_guard (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .chkValid(chkValid),
    .chkAddr(chkAddr), .chkUser(chkUser), .chkKind(chkKind),
    .resValid(resValid), .resGrant(resGrant), .resDeny(resDeny),
    .resRegion(resRegion), .resDefault(resDefault)
  );

  // {addr, user, kind, grant, default, region}; kind 0 exec, 1 write, 2 read
  localparam int NV = 15;
  localparam logic [40:0] VEC [NV] = '{
    {32'h0001_0004, 1'b1, 2'd2, 1'b1, 1'b0, 4'd2},
    {32'h0001_0004, 1'b1, 2'd1, 1'b0, 1'b0, 4'd2},
    {32'h0001_0004, 1'b0, 2'd1, 1'b1, 1'b0, 4'd2},
    {32'h0001_8010, 1'b0, 2'd2, 1'b0, 1'b0, 4'd1},
    {32'h0001_87FF, 1'b0, 2'd2, 1'b0, 1'b0, 4'd1},
    {32'h0001_8800, 1'b0, 2'd2, 1'b1, 1'b0, 4'd2},
    {32'h0001_FFFF, 1'b1, 2'd0, 1'b0, 1'b0, 4'd2},
    {32'h0002_0000, 1'b1, 2'd1, 1'b1, 1'b0, 4'd5},
    {32'h0002_1FFF, 1'b1, 2'd0, 1'b1, 1'b0, 4'd5},
    {32'h0002_2000, 1'b0, 2'd2, 1'b1, 1'b1, 4'd0},
    {32'h0002_2000, 1'b0, 2'd1, 1'b0, 1'b1, 4'd0},
    {32'h0003_0000, 1'b0, 2'd2, 1'b1, 1'b1, 4'd0},
    {32'h0003_0000, 1'b1, 2'd2, 1'b0, 1'b1, 4'd0},
    {32'h0000_FFFF, 1'b0, 2'd2, 1'b1, 1'b1, 4'd0},
    {32'h0001_0000, 1'b0, 2'd3, 1'b0, 1'b0, 4'd2}
  };

  task automatic note(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic writeReg(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readCheck(input logic [5:0] a, input logic [31:0] exp,
                           input string tag);
    @(negedge clk);
    regAddr = a;
    #1;
    note(regRdData === exp, tag, regRdData, exp);
  endtask

  task automatic runCheck(input logic [31:0] a, input logic u, input logic [1:0] k,
                          input logic eg, input logic ed, input logic [3:0] er,
                          input string tag);
    logic [31:0] act, exp;
    @(negedge clk);
    chkAddr = a; chkUser = u; chkKind = k; chkValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chkValid = 1'b0;
    act = {24'd0, resValid, resGrant, resDeny, resDefault, resRegion};
    exp = {24'd0, 1'b1, eg, ~eg, ed, er};
    note(act === exp, tag, act, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    note(resValid === 1'b0, "R1 resValid in reset", {31'd0, resValid}, 32'd0);
    readCheck(6'd4, 32'd0, "R1 perm word in reset");
    rstN = 1'b1;
    readCheck(6'd5, 32'd0, "R1 base word after reset");
    readCheck(6'd32, 32'd0, "R1 control word after reset");

    // program windows
    writeReg(6'd4,  32'h0000_07E3); writeReg(6'd5,  32'h0001_0001); // win 2, 64KB
    writeReg(6'd2,  32'h0000_0402); writeReg(6'd3,  32'h0001_8001); // win 1, 2KB
    writeReg(6'd10, 32'h0000_07F8); writeReg(6'd11, 32'h0002_0001); // win 5, 8KB
    writeReg(6'd6,  32'h0000_0600); writeReg(6'd7,  32'h0002_0000); // win 3 not valid
    writeReg(6'd8,  32'h0000_0401); writeReg(6'd9,  32'h0003_0001); // win 4 code 9
    writeReg(6'd32, 32'h4000_0100);                                 // on, kernel read
    writeReg(6'd33, 32'hFFFF_FFFF);                                 // unmapped

    // R2: readback and unmapped addresses
    readCheck(6'd4,  32'h0000_07E3, "R2 perm readback");
    readCheck(6'd5,  32'h0001_0001, "R2 base readback");
    readCheck(6'd32, 32'h4000_0100, "R2 control readback");
    readCheck(6'd33, 32'd0,         "R2 unmapped read is zero");

    // table: R4 R5 R6 R7 R8 R10 R11
    for (int i = 0; i < NV; i++) begin
      runCheck(VEC[i][40:9], VEC[i][8], VEC[i][7:6], VEC[i][5], VEC[i][4],
               VEC[i][3:0], $sformatf("R4 R5 R6 R7 R8 R10 R11 vector %0d", i));
    end

    // R9: verdict lasts one cycle only
    runCheck(32'h0002_0000, 1'b0, 2'd2, 1'b1, 1'b0, 4'd5, "R9 single verdict");
    @(negedge clk);
    note(resValid === 1'b0, "R9 resValid drops", {31'd0, resValid}, 32'd0);

    // R3: protection off grants everything
    writeReg(6'd32, 32'h0000_0100);
    runCheck(32'h0001_8010, 1'b0, 2'd2, 1'b1, 1'b0, 4'd0, "R3 off grants window 1");
    runCheck(32'h0001_0000, 1'b1, 2'd3, 1'b1, 1'b0, 4'd0, "R3 off grants reserved kind");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule